// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block converts a 32-bit virtual address into a physical address by reading one or two descriptors from memory. A walk begins with a read at an address built from a programmable table base and the top twelve virtual address bits. The descriptor returned there either maps a 1 MB region at once, or points to a second table. In that second case a further read returns a descriptor that maps a 64 KB or a 4 KB region. The physical address is always built by joining the upper bits of the final descriptor with the low virtual address bits.

The walker has a single read port toward memory. It sends one request pulse and then waits for the read-valid response, for any number of cycles. Each walk ends in a one-cycle completion pulse that carries the physical address and the region size. It can instead end in a one-cycle fault pulse that reports which level held the invalid descriptor. The table base can only be written while no walk is in progress.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1 and `mem_req_o`, `done_o` and `fault_o` are 0.
- R2: A request accepted in idle (`req_valid_i` high at a clock edge) drives `mem_req_o` in the next cycle. In that cycle `mem_addr_o` = {table base, VA[31:20], 2'b00}.
- R3: Every `mem_req_o` pulse lasts exactly one cycle. No further request is made until `mem_rvalid_i` is seen. A `mem_rvalid_i` that arrives while no read is outstanding is ignored.
- R4: A first-level descriptor with bits [1:0] = 10 is a section. The walk completes in the cycle after the response, with no second read. It gives `pa_o` = {desc[31:20], VA[19:0]} and `size_o` = 0.
- R5: A first-level descriptor with bits [1:0] = 01 is a table pointer. In the cycle after the response, a second read is issued at {desc[31:10], VA[19:12], 2'b00}.
- R6: A second-level descriptor with bits [1:0] = 01 is a large page. It gives `pa_o` = {desc[31:16], VA[15:0]} and `size_o` = 1.
- R7: A second-level descriptor with bits [1:0] = 10 or 11 is a small page. It gives `pa_o` = {desc[31:12], VA[11:0]} and `size_o` = 2.
- R8: A first-level descriptor with bits [1:0] = 00 or 11 raises `fault_o` with `fault_lvl_o` = 0 in the cycle after the response.
- R9: A second-level descriptor with bits [1:0] = 00 raises `fault_o` with `fault_lvl_o` = 1 in the cycle after the response.
- R10: `done_o` and `fault_o` are exclusive one-cycle pulses. The walker is idle again in the following cycle.
- R11: `base_we_i` loads the table base only while idle; a write at any other time is ignored. A write in the same cycle that a request is accepted already applies to that walk.
- R12: The result timing depends only on when the response arrives, whatever the delay between request and response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Write strobe for the table base |
| base_wdata_i | input | 18 | New table base (address bits 31:14) |
| req_valid_i | input | 1 | Start a walk for `req_va_i` |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor read data |
| done_o | output | 1 | Walk finished with a translation |
| pa_o | output | 32 | Physical address of the last translation |
| size_o | output | 2 | Region size: 0 = 1 MB, 1 = 64 KB, 2 = 4 KB |
| fault_o | output | 1 | Walk ended on an invalid descriptor |
| fault_lvl_o | output | 1 | Fault level: 0 = first, 1 = second |

## Verification
The hardest cases to reach are table-base writes and stray response strobes that arrive while a walk is in progress, because the normal flow never produces them. The bench brings them about directly. It writes the base while a first-level read is outstanding, then checks the next walk's first read address. It also pulses the response strobe while the walker is idle. In addition, it sweeps every descriptor type at both levels against several addresses, two table bases and three response delays.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_L1    = 3'd1,
    ST_L2    = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } state_e;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'd0,
    SZ_LARGE   = 2'd1,
    SZ_SMALL   = 2'd2
  } size_e;

  localparam logic [1:0] KIND_FAULT = 2'b00;
  localparam logic [1:0] KIND_LINK  = 2'b01;
  localparam logic [1:0] KIND_SECT  = 2'b10;
endpackage

// File: rtl/xlat_base_reg.sv
module xlat_base_reg #(
  parameter int BASE_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              we_i,
  input  logic [BASE_W-1:0] wdata_i,
  output logic [BASE_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_o <= '0;
    else if (we_i && idle_i) base_o <= wdata_i;
  end
endmodule

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode #(
  parameter int LEVEL = 1
) (
  input  logic [1:0]      kind_i,
  output logic            fault_o,
  output logic            link_o,
  output xlat_pkg::size_e size_o
);
  import xlat_pkg::*;

  generate
    if (LEVEL == 1) begin : g_first
      always_comb begin
        fault_o = (kind_i == KIND_FAULT) || (kind_i == 2'b11);
        link_o  = (kind_i == KIND_LINK);
        size_o  = SZ_SECTION;
      end
    end else begin : g_second
      always_comb begin
        fault_o = (kind_i == KIND_FAULT);
        link_o  = 1'b0;
        size_o  = (kind_i == KIND_LINK) ? SZ_LARGE : SZ_SMALL;
      end
    end
  endgenerate
endmodule

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int VA_W        = 32,
  parameter int L1_IDX_W    = 12,
  parameter int L2_IDX_W    = 8,
  parameter int LARGE_OFF_W = 16,
  parameter int SMALL_OFF_W = 12,
  parameter int BASE_W      = VA_W - L1_IDX_W - 2,
  parameter int TBL_W       = VA_W - L2_IDX_W - 2
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [TBL_W-1:0]  tbl_i,
  input  logic [VA_W-1:0]   leaf_i,
  input  xlat_pkg::size_e   size_i,
  output logic [VA_W-1:0]   l1_addr_o,
  output logic [VA_W-1:0]   l2_addr_o,
  output logic [VA_W-1:0]   pa_o
);
  import xlat_pkg::*;

  localparam int SEC_OFF_W = VA_W - L1_IDX_W;

  assign l1_addr_o = {base_i, va_i[VA_W-1 -: L1_IDX_W], 2'b00};
  assign l2_addr_o = {tbl_i, va_i[SEC_OFF_W-1 -: L2_IDX_W], 2'b00};

  always_comb begin
    unique case (size_i)
      SZ_SECTION: pa_o = {leaf_i[VA_W-1:SEC_OFF_W], va_i[SEC_OFF_W-1:0]};
      SZ_LARGE:   pa_o = {leaf_i[VA_W-1:LARGE_OFF_W], va_i[LARGE_OFF_W-1:0]};
      default:    pa_o = {leaf_i[VA_W-1:SMALL_OFF_W], va_i[SMALL_OFF_W-1:0]};
    endcase
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int VA_W        = 32,
  parameter int L1_IDX_W    = 12,
  parameter int L2_IDX_W    = 8,
  parameter int LARGE_OFF_W = 16,
  parameter int SMALL_OFF_W = 12,
  parameter int BASE_W      = VA_W - L1_IDX_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic [VA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [VA_W-1:0]   mem_rdata_i,
  output logic              done_o,
  output logic [VA_W-1:0]   pa_o,
  output logic [1:0]        size_o,
  output logic              fault_o,
  output logic              fault_lvl_o
);
  import xlat_pkg::*;

  localparam int TBL_W = VA_W - L2_IDX_W - 2;

  state_e            state_q;
  logic              issued_q;
  logic [VA_W-1:0]   va_q;
  logic [TBL_W-1:0]  tbl_q;
  logic [VA_W-1:0]   pa_q;
  size_e             size_q;
  logic              flt_lvl_q;
  logic [BASE_W-1:0] base_q;

  logic              idle;
  logic              resp;
  logic              f1_fault, f1_link;
  logic              f2_fault, f2_link;
  size_e             f1_size, f2_size, leaf_size;
  logic [VA_W-1:0]   l1_addr, l2_addr, pa_next;

  assign idle = (state_q == ST_IDLE);
  assign resp = issued_q && mem_rvalid_i;

  xlat_base_reg #(.BASE_W(BASE_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (idle),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .base_o  (base_q)
  );

  xlat_desc_decode #(.LEVEL(1)) u_dec1 (
    .kind_i  (mem_rdata_i[1:0]),
    .fault_o (f1_fault),
    .link_o  (f1_link),
    .size_o  (f1_size)
  );

  xlat_desc_decode #(.LEVEL(2)) u_dec2 (
    .kind_i  (mem_rdata_i[1:0]),
    .fault_o (f2_fault),
    .link_o  (f2_link),
    .size_o  (f2_size)
  );

  assign leaf_size = (state_q == ST_L2) ? f2_size : f1_size;

  xlat_addr_gen #(
    .VA_W        (VA_W),
    .L1_IDX_W    (L1_IDX_W),
    .L2_IDX_W    (L2_IDX_W),
    .LARGE_OFF_W (LARGE_OFF_W),
    .SMALL_OFF_W (SMALL_OFF_W),
    .BASE_W      (BASE_W),
    .TBL_W       (TBL_W)
  ) u_agen (
    .base_i    (base_q),
    .va_i      (va_q),
    .tbl_i     (tbl_q),
    .leaf_i    (mem_rdata_i),
    .size_i    (leaf_size),
    .l1_addr_o (l1_addr),
    .l2_addr_o (l2_addr),
    .pa_o      (pa_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      issued_q  <= 1'b0;
      va_q      <= '0;
      tbl_q     <= '0;
      pa_q      <= '0;
      size_q    <= SZ_SECTION;
      flt_lvl_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q     <= req_va_i;
            issued_q <= 1'b0;
            state_q  <= ST_L1;
          end
        end
        ST_L1: begin
          if (!issued_q) begin
            issued_q <= 1'b1;
          end else if (resp) begin
            issued_q <= 1'b0;
            if (f1_fault) begin
              flt_lvl_q <= 1'b0;
              state_q   <= ST_FAULT;
            end else if (f1_link) begin
              tbl_q   <= mem_rdata_i[VA_W-1 -: TBL_W];
              state_q <= ST_L2;
            end else begin
              pa_q    <= pa_next;
              size_q  <= f1_size;
              state_q <= ST_DONE;
            end
          end
        end
        ST_L2: begin
          if (!issued_q) begin
            issued_q <= 1'b1;
          end else if (resp) begin
            issued_q <= 1'b0;
            if (f2_fault || f2_link) begin
              flt_lvl_q <= 1'b1;
              state_q   <= ST_FAULT;
            end else begin
              pa_q    <= pa_next;
              size_q  <= f2_size;
              state_q <= ST_DONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = idle;
  assign mem_req_o   = ((state_q == ST_L1) || (state_q == ST_L2)) && !issued_q;
  assign mem_addr_o  = (state_q == ST_L2) ? l2_addr : l1_addr;
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = (state_q == ST_FAULT);
  assign pa_o        = pa_q;
  assign size_o      = size_q;
  assign fault_lvl_o = flt_lvl_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int BASE_W   = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [1:0]        size_o,
  input logic [VA_W-1:0]   pa_o,
  input logic [VA_W-1:0]   va_q,
  input logic [BASE_W-1:0] base_q
);
  localparam int SEC_OFF_W = VA_W - L1_IDX_W;

  p_start_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_req_o);

  p_single_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_section_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == 2'd0) |-> pa_o[SEC_OFF_W-1:0] == va_q[SEC_OFF_W-1:0]);

  p_small_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == 2'd2) |-> pa_o[11:0] == va_q[11:0]);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  p_back_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> req_ready_o);

  p_base_lock_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(base_q));
endmodule

bind xlat_walker xlat_walker_chk #(
  .VA_W     (VA_W),
  .L1_IDX_W (L1_IDX_W),
  .BASE_W   (BASE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .size_o      (size_o),
  .pa_o        (pa_o),
  .va_q        (va_q),
  .base_q      (base_q)
);

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_we_i = 1'b0;
  logic [17:0] base_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        req_ready_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o;
  logic [31:0] pa_o;
  logic [1:0]  size_o;
  logic        fault_o;
  logic        fault_lvl_o;

  int checks = 0;
  int errors = 0;
  logic [17:0] cur_base = '0;

  always #2 clk_i = ~clk_i;

  xlat_walker uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
    .req_valid_i(req_valid_i), .req_va_i(req_va_i), .req_ready_o(req_ready_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .pa_o(pa_o), .size_o(size_o),
    .fault_o(fault_o), .fault_lvl_o(fault_lvl_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_base(input logic [17:0] b);
    @(negedge clk_i);
    base_we_i = 1'b1; base_wdata_i = b;
    @(negedge clk_i);
    base_we_i = 1'b0;
    cur_base = b;
  endtask

  // waits out the issue cycle and the delay, then presents one response
  task automatic respond(input logic [31:0] d, input int dly);
    @(negedge clk_i);
    for (int k = 0; k < dly; k++) begin
      chk(!mem_req_o, "R3", {31'd0, mem_req_o}, 32'd0);
      @(negedge clk_i);
    end
    chk(!mem_req_o, "R3", {31'd0, mem_req_o}, 32'd0);
    mem_rvalid_i = 1'b1; mem_rdata_i = d;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0; mem_rdata_i = '0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2, input int dly);
    logic [31:0] exp;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    exp = {cur_base, va[31:20], 2'b00};
    chk(mem_req_o === 1'b1, "R2", {31'd0, mem_req_o}, 32'd1);
    chk(mem_addr_o === exp, "R2", mem_addr_o, exp);
    respond(d1, dly);
    case (d1[1:0])
      2'b00, 2'b11: begin
        chk(fault_o && !done_o, "R8 R12", {30'd0, done_o, fault_o}, 32'd1);
        chk(fault_lvl_o === 1'b0, "R8", {31'd0, fault_lvl_o}, 32'd0);
        chk(!mem_req_o, "R8", {31'd0, mem_req_o}, 32'd0);
      end
      2'b10: begin
        exp = {d1[31:20], va[19:0]};
        chk(done_o && !fault_o, "R4 R12", {30'd0, done_o, fault_o}, 32'd2);
        chk(pa_o === exp, "R4", pa_o, exp);
        chk(size_o === 2'd0, "R4", {30'd0, size_o}, 32'd0);
        chk(!mem_req_o, "R4", {31'd0, mem_req_o}, 32'd0);
      end
      default: begin
        exp = {d1[31:10], va[19:12], 2'b00};
        chk(mem_req_o === 1'b1, "R5", {31'd0, mem_req_o}, 32'd1);
        chk(mem_addr_o === exp, "R5", mem_addr_o, exp);
        respond(d2, dly);
        if (d2[1:0] == 2'b00) begin
          chk(fault_o && !done_o, "R9 R12", {30'd0, done_o, fault_o}, 32'd1);
          chk(fault_lvl_o === 1'b1, "R9", {31'd0, fault_lvl_o}, 32'd1);
        end else if (d2[1:0] == 2'b01) begin
          exp = {d2[31:16], va[15:0]};
          chk(done_o && !fault_o, "R6 R12", {30'd0, done_o, fault_o}, 32'd2);
          chk(pa_o === exp, "R6", pa_o, exp);
          chk(size_o === 2'd1, "R6", {30'd0, size_o}, 32'd1);
        end else begin
          exp = {d2[31:12], va[11:0]};
          chk(done_o && !fault_o, "R7 R12", {30'd0, done_o, fault_o}, 32'd2);
          chk(pa_o === exp, "R7", pa_o, exp);
          chk(size_o === 2'd2, "R7", {30'd0, size_o}, 32'd2);
        end
      end
    endcase
    @(negedge clk_i);
    chk(req_ready_o && !done_o && !fault_o, "R10", {29'd0, req_ready_o, done_o, fault_o}, 32'd4);
  endtask

  initial begin
    #(100000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vas [4];
    logic [31:0] h;
    vas[0] = 32'h0000_0000; vas[1] = 32'hFFFF_FFFF;
    vas[2] = 32'h1234_5678; vas[3] = 32'hA5C3_3C5A;

    #1;
    chk(req_ready_o === 1'b1 && mem_req_o === 1'b0 && done_o === 1'b0 && fault_o === 1'b0,
        "R1", {28'd0, req_ready_o, mem_req_o, done_o, fault_o}, 32'h8);
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o === 1'b1 && mem_req_o === 1'b0, "R1", {30'd0, req_ready_o, mem_req_o}, 32'h2);

    // sweep: two bases, four addresses, every descriptor kind, three delays
    for (int b = 0; b < 2; b++) begin
      write_base(b == 0 ? 18'h0_0000 : 18'h2_A5F3);
      for (int v = 0; v < 4; v++)
        for (int t1 = 0; t1 < 4; t1++)
          for (int t2 = 0; t2 < 4; t2++)
            for (int dly = 0; dly < 3; dly++) begin
              if (t1 != 1 && t2 != 0) continue;
              h = (32'h9E37_79B9 * (v * 16 + t1 * 4 + t2 + b * 64 + 1)) ^ 32'h5A5A_0F0F;
              walk(vas[v], {h[31:2], 2'(t1)}, {h[15:0], h[31:18], 2'(t2)}, dly);
            end
    end

    // stray response while idle is ignored
    @(negedge clk_i);
    mem_rvalid_i = 1'b1; mem_rdata_i = 32'hFFF0_0002;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    chk(req_ready_o && !done_o && !fault_o && !mem_req_o, "R3",
        {28'd0, req_ready_o, done_o, fault_o, mem_req_o}, 32'h8);
    walk(32'h0ABC_DEF0, 32'h7770_0002, 32'd0, 1);

    // base write during a walk is ignored
    write_base(18'h1_1111);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = 32'h3210_0000;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    base_we_i = 1'b1; base_wdata_i = 18'h3_FFFF;
    @(negedge clk_i);
    base_we_i = 1'b0;
    mem_rvalid_i = 1'b1; mem_rdata_i = 32'h0010_0002;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    chk(done_o === 1'b1, "R11", {31'd0, done_o}, 32'd1);
    @(negedge clk_i);
    walk(32'h4560_0000, 32'h0020_0002, 32'd0, 0);
    chk(cur_base == 18'h1_1111, "R11", {14'd0, cur_base}, 32'h1_1111);

    // base write coinciding with an accepted request applies to it
    @(negedge clk_i);
    base_we_i = 1'b1; base_wdata_i = 18'h0_0ACE;
    req_valid_i = 1'b1; req_va_i = 32'h8010_0000;
    @(negedge clk_i);
    base_we_i = 1'b0; req_valid_i = 1'b0;
    chk(mem_req_o && mem_addr_o === {18'h0_0ACE, 12'h801, 2'b00}, "R11",
        mem_addr_o, {18'h0_0ACE, 12'h801, 2'b00});
    cur_base = 18'h0_0ACE;
    respond(32'hABC0_0002, 2);
    chk(done_o && pa_o === 32'hABC0_0000, "R11", pa_o, 32'hABC0_0000);
    @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule